// File: doc/BRIEF.md
# Critical-Word-First Line Filler

This block services data-cache misses for a write-back cache whose lines hold eight 32-bit words, which is four 64-bit double words. When a load misses, the block latches the miss address and, if the line it is about to replace is modified, first copies that victim out to memory as a four-beat burst write. It then issues a burst read for the missing line.

Memory returns the double word the load asked for first. The remaining beats follow in wrap-around order. Each beat is written into the cache data RAM in the cycle it is acknowledged. The first beat also goes straight to the waiting load unit in that same cycle, so the load does not wait for the rest of the line. The line is declared valid one cycle after its last beat is stored.

An access marked non-cacheable skips all of this. It performs a single-beat read, hands the data to the requester and leaves the cache untouched. The bus side uses a request/grant pair for the address phase and one data acknowledge per beat.

Top module: `cache_line_filler`

## Requirements
- R1: After reset the block is idle: `reqReady` is 1 and `busReq`, `ramWrEn`, `fwdValid` and `lineValid` are all 0.
- R2: For a cacheable miss, `busReq` is raised with `busWrite`=0, `busBurst`=1 and `busAddr` equal to the miss address with its low 3 bits cleared. `busReq` stays high, with a stable address, until the cycle in which `busGrant` is 1, and it is low in the cycle after that.
- R3: The four read beats are written to the cache RAM in wrap order: double-word index `crit`, `crit+1`, `crit+2`, `crit+3` (modulo 4), where `crit` is miss address bits [4:3]. Each write happens in its acknowledge cycle, carries `busRdData` and uses set index = address bits [11:5].
- R4: `fwdValid` is a single-cycle pulse in the acknowledge cycle of the first read beat. In that cycle `fwdData` equals the critical double word, and the same word is being written to the RAM.
- R5: `lineValid` pulses for exactly one cycle, the cycle after the fourth beat is written, with `lineSet` equal to the line's set index. It is never high during the fill.
- R6: When the victim is dirty, the block first raises a burst write (`busWrite`=1, `busBurst`=1) to the line-aligned victim address. It sends victim double words 0,1,2,3 on `busWrData` (double word i is `victimLine` bits [64i+63:64i]) and only then requests the read.
- R7: A beat advances only in a cycle with `busDataAck`=1. In stall cycles no RAM write and no forward occur.
- R8: A non-cacheable request (`reqNoCache`=1) performs one single-beat read (`busBurst`=0, dword-aligned address), even if `victimDirty` is 1. It forwards the data with `fwdValid`, and never asserts `ramWrEn` or `lineValid`.
- R9: While a transaction is in progress `reqReady` is 0, and changes on the request inputs have no effect on bus addresses, written data or forwarded data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Miss request present |
| reqReady | output | 1 | Block idle, request accepted this cycle |
| reqAddr | input | ADDR_W | Byte address of the missing load |
| reqNoCache | input | 1 | Access is non-cacheable (single beat, no allocation) |
| victimDirty | input | 1 | Line being replaced is modified |
| victimAddr | input | ADDR_W | Address of the line being replaced |
| victimLine | input | BEATS*DW_W | Contents of the line being replaced |
| fwdValid | output | 1 | Critical data valid for the requester |
| fwdData | output | DW_W | Critical double word |
| ramWrEn | output | 1 | Cache data RAM write strobe |
| ramWrSet | output | SET_W | RAM set index |
| ramWrDw | output | BEAT_W | Double-word index within the line |
| ramWrData | output | DW_W | RAM write data |
| lineValid | output | 1 | Line complete, mark it valid |
| lineSet | output | SET_W | Set of the completed line |
| busReq | output | 1 | Address-phase request |
| busGrant | input | 1 | Address-phase grant |
| busWrite | output | 1 | Transaction direction is write |
| busBurst | output | 1 | Transaction is a four-beat burst |
| busAddr | output | ADDR_W | Transaction address |
| busWrData | output | DW_W | Write beat data |
| busRdData | input | DW_W | Read beat data |
| busDataAck | input | 1 | Beat acknowledge |

## Verification
The fill is run from each of the four critical start positions. A fill that used linear rather than wrap order, or that forwarded a beat other than the first, shows up as a wrong RAM index or wrong forwarded word. A dirty-victim miss run with stalled grants and acknowledges separates a design that orders the castout before the read and holds beats on missing acknowledges from one that does not. During that run the request inputs toggle with unrelated values, which shows that busy-time requests are ignored. A non-cacheable request with a dirty victim tells single-beat, non-allocating reads apart from ordinary fills.

// File: rtl/cache_line_filler_pkg.sv
package cache_line_filler_pkg;

  // strobes from control to datapath
  typedef struct packed {
    logic latch;    // capture request and victim
    logic beatClr;  // restart beat counter
    logic beatInc;  // advance to next beat
  } fillCtl_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WB_ADDR,
    ST_WB_DATA,
    ST_RD_ADDR,
    ST_RD_DATA,
    ST_FIN
  } fillState_t;

endpackage

// File: rtl/cache_line_filler_datapath.sv
module cache_line_filler_datapath
  import cache_line_filler_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DW_W   = 64,
  parameter int BEATS  = 4,
  parameter int SET_W  = 7,
  localparam int BEAT_W   = $clog2(BEATS),
  localparam int DW_OFF   = $clog2(DW_W / 8),
  localparam int LINE_OFF = DW_OFF + BEAT_W
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  fillCtl_t                ctl,
  input  logic [ADDR_W-1:DW_OFF]  reqAddr,
  input  logic [ADDR_W-1:LINE_OFF] victimAddr,
  input  logic [BEATS*DW_W-1:0]   victimLine,
  output logic                    firstBeat,
  output logic                    lastBeat,
  output logic [ADDR_W-1:0]       rdBusAddr,
  output logic [ADDR_W-1:0]       wbBusAddr,
  output logic [DW_W-1:0]         wbData,
  output logic [BEAT_W-1:0]       ramWrDw,
  output logic [SET_W-1:0]        ramWrSet
);

  logic [ADDR_W-1:DW_OFF]   addrQ;
  logic [ADDR_W-1:LINE_OFF] vAddrQ;
  logic [BEATS*DW_W-1:0]    vLineQ;
  logic [BEAT_W-1:0]        beatQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrQ  <= '0;
      vAddrQ <= '0;
      vLineQ <= '0;
    end else if (ctl.latch) begin
      addrQ  <= reqAddr;
      vAddrQ <= victimAddr;
      vLineQ <= victimLine;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)            beatQ <= '0;
    else if (ctl.beatClr) beatQ <= '0;
    else if (ctl.beatInc) beatQ <= beatQ + 1'b1;
  end

  assign firstBeat = (beatQ == '0);
  assign lastBeat  = (beatQ == BEAT_W'(BEATS - 1));

  // wrap ordering: counter offset from the critical double word, modulo line size
  assign ramWrDw   = addrQ[DW_OFF +: BEAT_W] + beatQ;
  assign ramWrSet  = addrQ[LINE_OFF +: SET_W];
  assign rdBusAddr = {addrQ, {DW_OFF{1'b0}}};
  assign wbBusAddr = {vAddrQ, {LINE_OFF{1'b0}}};
  assign wbData    = vLineQ[beatQ*DW_W +: DW_W];

  // consecutive beats step the double-word index by one (wrapping)
  assert_wrap_step_R3: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.beatInc && $past(ctl.beatInc)) |-> (ramWrDw == BEAT_W'($past(ramWrDw) + 1'b1)));

endmodule

// File: rtl/cache_line_filler_control.sv
module cache_line_filler_control
  import cache_line_filler_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     reqValid,
  input  logic     reqNoCache,
  input  logic     victimDirty,
  input  logic     busGrant,
  input  logic     busDataAck,
  input  logic     firstBeat,
  input  logic     lastBeat,
  output fillCtl_t ctl,
  output logic     reqReady,
  output logic     busReq,
  output logic     busWrite,
  output logic     busBurst,
  output logic     selWb,
  output logic     ramWrEn,
  output logic     fwdValid,
  output logic     lineValid
);

  fillState_t state, nextState;
  logic ncQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      ncQ   <= 1'b0;
    end else begin
      state <= nextState;
      if (ctl.latch) ncQ <= reqNoCache;
    end
  end

  always_comb begin
    nextState = state;
    ctl       = '0;
    reqReady  = 1'b0;
    busReq    = 1'b0;
    busWrite  = 1'b0;
    busBurst  = 1'b0;
    selWb     = 1'b0;
    ramWrEn   = 1'b0;
    fwdValid  = 1'b0;
    lineValid = 1'b0;
    unique case (state)
      ST_IDLE: begin
        reqReady = 1'b1;
        if (reqValid) begin
          ctl.latch   = 1'b1;
          ctl.beatClr = 1'b1;
          nextState   = (!reqNoCache && victimDirty) ? ST_WB_ADDR : ST_RD_ADDR;
        end
      end
      ST_WB_ADDR: begin
        busReq   = 1'b1;
        busWrite = 1'b1;
        busBurst = 1'b1;
        selWb    = 1'b1;
        if (busGrant) nextState = ST_WB_DATA;
      end
      ST_WB_DATA: begin
        busWrite = 1'b1;
        selWb    = 1'b1;
        if (busDataAck) begin
          if (lastBeat) begin
            ctl.beatClr = 1'b1;
            nextState   = ST_RD_ADDR;
          end else begin
            ctl.beatInc = 1'b1;
          end
        end
      end
      ST_RD_ADDR: begin
        busReq   = 1'b1;
        busBurst = !ncQ;
        if (busGrant) nextState = ST_RD_DATA;
      end
      ST_RD_DATA: begin
        if (busDataAck) begin
          ramWrEn  = !ncQ;
          fwdValid = firstBeat;
          if (ncQ || lastBeat) begin
            ctl.beatClr = 1'b1;
            nextState   = ST_FIN;
          end else begin
            ctl.beatInc = 1'b1;
          end
        end
      end
      ST_FIN: begin
        lineValid = !ncQ;
        nextState = ST_IDLE;
      end
      default: nextState = ST_IDLE;
    endcase
  end

  assert_req_hold_R2: assert property (@(posedge clk) disable iff (!rstN)
    (busReq && !busGrant) |=> busReq);

  assert_req_drop_R2: assert property (@(posedge clk) disable iff (!rstN)
    (busReq && busGrant) |=> !busReq);

  assert_fwd_pulse_R4: assert property (@(posedge clk) disable iff (!rstN)
    fwdValid |=> !fwdValid);

  assert_valid_after_write_R5: assert property (@(posedge clk) disable iff (!rstN)
    lineValid |-> ($past(ramWrEn) && $past(busDataAck)));

  assert_no_alloc_R8: assert property (@(posedge clk) disable iff (!rstN)
    (ncQ && !reqReady) |-> (!ramWrEn && !lineValid));

endmodule

// File: rtl/cache_line_filler.sv
module cache_line_filler
  import cache_line_filler_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DW_W   = 64,
  parameter int BEATS  = 4,
  parameter int SET_W  = 7,
  localparam int BEAT_W   = $clog2(BEATS),
  localparam int DW_OFF   = $clog2(DW_W / 8),
  localparam int LINE_OFF = DW_OFF + BEAT_W
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  reqValid,
  output logic                  reqReady,
  input  logic [ADDR_W-1:0]     reqAddr,
  input  logic                  reqNoCache,
  input  logic                  victimDirty,
  input  logic [ADDR_W-1:0]     victimAddr,
  input  logic [BEATS*DW_W-1:0] victimLine,
  output logic                  fwdValid,
  output logic [DW_W-1:0]       fwdData,
  output logic                  ramWrEn,
  output logic [SET_W-1:0]      ramWrSet,
  output logic [BEAT_W-1:0]     ramWrDw,
  output logic [DW_W-1:0]       ramWrData,
  output logic                  lineValid,
  output logic [SET_W-1:0]      lineSet,
  output logic                  busReq,
  input  logic                  busGrant,
  output logic                  busWrite,
  output logic                  busBurst,
  output logic [ADDR_W-1:0]     busAddr,
  output logic [DW_W-1:0]       busWrData,
  input  logic [DW_W-1:0]       busRdData,
  input  logic                  busDataAck
);

  fillCtl_t ctl;
  logic firstBeat, lastBeat, selWb;
  logic [ADDR_W-1:0] rdBusAddr, wbBusAddr;

  cache_line_filler_control ctrl_i (
    .clk        (clk),
    .rstN       (rstN),
    .reqValid   (reqValid),
    .reqNoCache (reqNoCache),
    .victimDirty(victimDirty),
    .busGrant   (busGrant),
    .busDataAck (busDataAck),
    .firstBeat  (firstBeat),
    .lastBeat   (lastBeat),
    .ctl        (ctl),
    .reqReady   (reqReady),
    .busReq     (busReq),
    .busWrite   (busWrite),
    .busBurst   (busBurst),
    .selWb      (selWb),
    .ramWrEn    (ramWrEn),
    .fwdValid   (fwdValid),
    .lineValid  (lineValid)
  );

  cache_line_filler_datapath #(
    .ADDR_W(ADDR_W), .DW_W(DW_W), .BEATS(BEATS), .SET_W(SET_W)
  ) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .ctl       (ctl),
    .reqAddr   (reqAddr[ADDR_W-1:DW_OFF]),
    .victimAddr(victimAddr[ADDR_W-1:LINE_OFF]),
    .victimLine(victimLine),
    .firstBeat (firstBeat),
    .lastBeat  (lastBeat),
    .rdBusAddr (rdBusAddr),
    .wbBusAddr (wbBusAddr),
    .wbData    (busWrData),
    .ramWrDw   (ramWrDw),
    .ramWrSet  (ramWrSet)
  );

  // read beats go to the RAM and the requester in the same cycle
  assign busAddr   = selWb ? wbBusAddr : rdBusAddr;
  assign ramWrData = busRdData;
  assign fwdData   = busRdData;
  assign lineSet   = ramWrSet;

endmodule

// File: tb/cache_line_filler_tb_top.sv
`timescale 1ns/1ps
module cache_line_filler_tb_top;
  localparam int ADDR_W = 32;
  localparam int DW_W   = 64;
  localparam int BEATS  = 4;
  localparam int SET_W  = 7;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0, reqNoCache = 1'b0, victimDirty = 1'b0;
  logic [ADDR_W-1:0] reqAddr = '0, victimAddr = '0;
  logic [BEATS*DW_W-1:0] victimLine = '0;
  logic busGrant = 1'b0, busDataAck = 1'b0;
  logic [DW_W-1:0] busRdData = '0;
  logic reqReady, fwdValid, ramWrEn, lineValid, busReq, busWrite, busBurst;
  logic [DW_W-1:0] fwdData, ramWrData, busWrData;
  logic [SET_W-1:0] ramWrSet, lineSet;
  logic [1:0] ramWrDw;
  logic [ADDR_W-1:0] busAddr;

  int nChecks = 0;
  int nFails  = 0;
  bit pokeQ   = 1'b0;

  always #2.5 clk = ~clk;

  cache_line_filler dut_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqAddr(reqAddr), .reqNoCache(reqNoCache), .victimDirty(victimDirty),
    .victimAddr(victimAddr), .victimLine(victimLine), .fwdValid(fwdValid),
    .fwdData(fwdData), .ramWrEn(ramWrEn), .ramWrSet(ramWrSet), .ramWrDw(ramWrDw),
    .ramWrData(ramWrData), .lineValid(lineValid), .lineSet(lineSet),
    .busReq(busReq), .busGrant(busGrant), .busWrite(busWrite), .busBurst(busBurst),
    .busAddr(busAddr), .busWrData(busWrData), .busRdData(busRdData),
    .busDataAck(busDataAck)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // behavioural memory: content derived from the dword address
  function automatic logic [63:0] memDw(input logic [31:0] a);
    return {a ^ 32'h5A5A_0F0F, ~a};
  endfunction

  // request inputs during busy cycles: junk when poking (R9)
  task automatic busyInputs();
    reqValid = pokeQ;
    if (pokeQ) begin
      reqAddr     = 32'hDEAD_BEE8;
      victimAddr  = 32'h0BAD_0000;
      victimDirty = 1'b0;
      reqNoCache  = 1'b1;
      victimLine  = '1;
    end
  endtask

  task automatic busPhase(input bit isWr, input int nBeats, input logic [31:0] expAddr,
                          input bit expBurst, input int gap, input logic [31:0] lineBase,
                          input int crit, input bit nc, input logic [63:0] vic [4]);
    int w = 0;
    do begin
      @(negedge clk); busGrant = 1'b0; busDataAck = 1'b0; busyInputs(); #1;
      w++;
    end while (!busReq && w < 20);
    chk(busReq, isWr ? "R6" : "R2", "request raised", 64'(busReq), 64'd1);
    for (int g = 0; g < gap; g++) begin
      @(negedge clk); busyInputs(); #1;
      chk(busReq, "R2", "request held without grant", 64'(busReq), 64'd1);
      chk(busAddr == expAddr, "R2", "address stable while waiting", 64'(busAddr), 64'(expAddr));
      if (pokeQ) chk(!reqReady, "R9", "not ready while busy", 64'(reqReady), 64'd0);
    end
    busGrant = 1'b1; #0.5;
    chk(busWrite == isWr, isWr ? "R6" : "R2", "direction", 64'(busWrite), 64'(isWr));
    chk(busBurst == expBurst, nc ? "R8" : "R2", "burst flag", 64'(busBurst), 64'(expBurst));
    chk(busAddr == expAddr, isWr ? "R6" : (nc ? "R8" : "R2"), "address", 64'(busAddr), 64'(expAddr));
    for (int b = 0; b < nBeats; b++) begin
      int idx = (crit + b) % 4;
      logic [63:0] d;
      for (int g = 0; g < gap; g++) begin
        @(negedge clk); busGrant = 1'b0; busDataAck = 1'b0; busyInputs(); #1;
        if (b == 0 && g == 0)
          chk(!busReq, "R2", "request dropped after grant", 64'(busReq), 64'd0);
        chk(!ramWrEn && !fwdValid, "R7", "no action on stall", 64'({ramWrEn, fwdValid}), 64'd0);
        if (pokeQ) chk(!reqReady, "R9", "not ready while busy", 64'(reqReady), 64'd0);
      end
      d = memDw(lineBase + 32'(idx * 8));
      @(negedge clk); busGrant = 1'b0; busDataAck = 1'b1; busRdData = d; busyInputs(); #1;
      if (isWr) begin
        chk(busWrData == vic[b], "R6", $sformatf("victim beat %0d", b), busWrData, vic[b]);
        chk(!ramWrEn, "R6", "no RAM write during castout", 64'(ramWrEn), 64'd0);
      end else if (nc) begin
        chk(fwdValid && fwdData == d, "R8", "single-beat forward", fwdData, d);
        chk(!ramWrEn, "R8", "no RAM write", 64'(ramWrEn), 64'd0);
      end else begin
        chk(ramWrEn, "R3", $sformatf("write on beat %0d", b), 64'(ramWrEn), 64'd1);
        chk(ramWrDw == 2'(idx), "R3", $sformatf("wrap index beat %0d", b), 64'(ramWrDw), 64'(idx));
        chk(ramWrData == d, "R3", "write data", ramWrData, d);
        chk(ramWrSet == lineBase[11:5], "R3", "set index", 64'(ramWrSet), 64'(lineBase[11:5]));
        chk(fwdValid == (b == 0), "R4", $sformatf("forward flag beat %0d", b), 64'(fwdValid), 64'(b == 0));
        if (b == 0) chk(fwdData == d, "R4", "critical forward data", fwdData, d);
        chk(!lineValid, "R5", "not valid mid-fill", 64'(lineValid), 64'd0);
      end
    end
  endtask

  task automatic doFill(input logic [31:0] addr, input logic [31:0] vAddr, input bit dirty,
                        input bit nc, input int gap, input bit poke);
    logic [31:0] lineBase = {addr[31:5], 5'b0};
    int crit = int'(addr[4:3]);
    logic [63:0] vic [4];
    for (int i = 0; i < 4; i++) vic[i] = {32'hC0DE_0000 | 32'(i), vAddr};
    @(negedge clk);
    reqAddr = addr; victimAddr = vAddr; victimDirty = dirty; reqNoCache = nc;
    victimLine = {vic[3], vic[2], vic[1], vic[0]}; reqValid = 1'b1;
    #1 chk(reqReady, "R1", "ready when idle", 64'(reqReady), 64'd1);
    pokeQ = poke;
    if (dirty && !nc)
      busPhase(1'b1, 4, {vAddr[31:5], 5'b0}, 1'b1, gap, lineBase, crit, nc, vic);
    busPhase(1'b0, nc ? 1 : 4, {addr[31:3], 3'b0}, !nc, gap, lineBase, crit, nc, vic);
    @(negedge clk); pokeQ = 1'b0; reqValid = 1'b0; busDataAck = 1'b0; #1;
    chk(!ramWrEn && !fwdValid, "R4", "no stray write/forward after fill", 64'({ramWrEn, fwdValid}), 64'd0);
    if (nc) chk(!lineValid, "R8", "no allocation", 64'(lineValid), 64'd0);
    else begin
      chk(lineValid, "R5", "line valid pulse", 64'(lineValid), 64'd1);
      chk(lineSet == addr[11:5], "R5", "valid set", 64'(lineSet), 64'(addr[11:5]));
    end
    @(negedge clk); #1;
    chk(!lineValid, "R5", "valid is one cycle", 64'(lineValid), 64'd0);
    chk(reqReady, "R9", "ready again after fill", 64'(reqReady), 64'd1);
  endtask

  task automatic testReset();
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1; #1;
    chk(reqReady, "R1", "reset ready", 64'(reqReady), 64'd1);
    chk(!busReq && !ramWrEn && !fwdValid && !lineValid, "R1", "reset strobes",
        64'({busReq, ramWrEn, fwdValid, lineValid}), 64'd0);
  endtask

  task automatic testCleanFills();
    for (int c = 0; c < 4; c++)
      doFill(32'h0001_2340 + 32'(c * 8) + 32'd4, 32'h0009_9900, 1'b0, 1'b0, 0, 1'b0); // R3 every start
  endtask

  task automatic testDirtyStalled();
    doFill(32'h0004_5650, 32'h0007_7F2C, 1'b1, 1'b0, 2, 1'b1); // R6 R7 R9, crit 2
  endtask

  task automatic testDirtyBackToBack();
    doFill(32'h0003_01F8, 32'h0002_0160, 1'b1, 1'b0, 0, 1'b0); // R6 crit 3
  endtask

  task automatic testNoCache();
    doFill(32'h0000_5554, 32'h0001_1100, 1'b1, 1'b1, 1, 1'b0); // R8 dirty ignored
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    testReset();
    testCleanFills();
    testDirtyStalled();
    testDirtyBackToBack();
    testNoCache();
    repeat (2) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule